// File: doc/BRIEF.md
# Printer Port Register Controller

This block is the register face of a standard printer port, together with a small model of the printer's own handshake. A host drives a narrow register bus with a 3-bit offset, 8-bit write data and separate read and write strobes. The block holds three registers: a data byte to send, a status byte that reports the modelled printer's state, and a control byte that carries the handshake lines. When software pulses the strobe line through the control register, the block hands the pending data byte to an output byte stream. Polling status then walks the printer through its busy/acknowledge sequence, one step per read, so a software driver that waits for the acknowledge sees the answer it expects.

Each rising edge of a strobe is one bus access. Read data is registered: it appears on the cycle after the read strobe rises and holds until the next read. It shows the register as it was before any side effect of that read. An interrupt level goes high when software drops the strobe line while interrupts are enabled. Any status read clears it. When the control register selects input direction, a data read returns an external input byte.

Top module: `prn_port_regs`

## Requirements
- R1: After reset, bus_rdata is 0xFF, irq and out_valid are 0, a status read returns 0xD9, a control read returns 0xCC and a data read returns 0xFF.
- R2: Offset 0 selects data, offset 1 status and offset 2 control. Reads of offsets 3 to 7 return 0xFF. Writes to offset 1 and to offsets 3 to 7 change no register.
- R3: A control write stores the written byte with bits 7 and 6 forced to 1.
- R4: A control write with bit 2 at 0 sets status to 0xD8.
- R5: A control write with bits 2 and 3 at 1 and bit 0 at 1 clears status bit 7. If the stored control bit 0 was 0 before that write, out_valid pulses high for exactly one cycle on the next cycle, and out_byte carries the stored data byte.
- R6: A control write with bits 2 and 3 at 1 and bit 0 at 0 sets the interrupt pending flag, but only if the previously stored control value had bit 4 set.
- R7: A status read returns status as it was before the read and clears the pending flag. After that read, if status bit 7 and stored control bit 0 are both 0, status bit 6 is cleared if it was 1. If bit 6 was already 0, bits 7 and 6 are both set.
- R8: A data read returns in_byte when stored control bit 5 is 1, and otherwise returns the last byte written to offset 0.
- R9: irq is a level equal to the pending flag. It rises on the cycle after the setting control write and stays high until a status read.
- R10: An access takes effect once per rising edge of its strobe, however long the strobe is held. If both strobes rise in the same cycle, only the write takes effect.
- R11: A control read returns the stored control value and changes no state.
- R12: bus_rdata changes only on the cycle after a read access. It holds its value through idle cycles and writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, rising edge starts one write |
| bus_rd | input | 1 | Read strobe, rising edge starts one read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| in_byte | input | 8 | External byte returned by data reads in input direction |
| out_valid | output | 1 | One-cycle pulse: a byte was handed to the printer |
| out_byte | output | 8 | Byte handed to the printer |
| irq | output | 1 | Interrupt level |

## Verification
The hardest state to reach is the polled acknowledge cycle. Status bit 7 must first be cleared by a strobe-high control write with the select and init bits set. The stored strobe must then be lowered, and that same write also arms the interrupt when enable was stored. Only in that state do consecutive status reads alternate bit 6 and then reload bits 7 and 6. The stimulus builds this exact control sequence, then polls repeatedly, including one poll whose read strobe is held for several cycles, to show that a held strobe advances the handshake only once.

// File: rtl/prn_port_pkg.sv
package prn_port_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd2;

  // control bit positions
  localparam int C_STRB = 0;
  localparam int C_INIT = 2;
  localparam int C_SEL  = 3;
  localparam int C_IEN  = 4;
  localparam int C_DIR  = 5;
  // status bit positions
  localparam int S_ACK  = 6;
  localparam int S_BUSY = 7;

  localparam logic [DATA_W-1:0] CTRL_FORCE = 8'hC0;
  localparam logic [DATA_W-1:0] CTRL_RST   = 8'hCC;
  localparam logic [DATA_W-1:0] STAT_RST   = 8'hD9;
  localparam logic [DATA_W-1:0] STAT_INIT  = 8'hD8;
  localparam logic [DATA_W-1:0] DATA_RST   = 8'hFF;
  localparam logic [DATA_W-1:0] UNMAPPED   = 8'hFF;

  typedef struct packed {
    logic reload;
    logic clr_busy;
    logic emit;
    logic set_pend;
  } ctl_effect_t;

  function automatic logic [DATA_W-1:0] ctl_fold(input logic [DATA_W-1:0] v);
    return v | CTRL_FORCE;
  endfunction

  function automatic ctl_effect_t ctl_decode(input logic [DATA_W-1:0] nv,
                                             input logic [DATA_W-1:0] pv);
    ctl_effect_t e;
    e = '0;
    if (!nv[C_INIT]) begin
      e.reload = 1'b1;
    end else if (nv[C_SEL]) begin
      if (nv[C_STRB]) begin
        e.clr_busy = 1'b1;
        e.emit     = !pv[C_STRB];
      end else begin
        e.set_pend = pv[C_IEN];
      end
    end
    return e;
  endfunction

  function automatic logic [DATA_W-1:0] poll_step(input logic [DATA_W-1:0] st,
                                                  input logic strobe);
    logic [DATA_W-1:0] n;
    n = st;
    if (!st[S_BUSY] && !strobe) begin
      if (st[S_ACK]) n[S_ACK] = 1'b0;
      else begin
        n[S_ACK]  = 1'b1;
        n[S_BUSY] = 1'b1;
      end
    end
    return n;
  endfunction

  function automatic logic [DATA_W-1:0] read_mux(input logic [ADDR_W-1:0] a,
                                                 input logic [DATA_W-1:0] dw,
                                                 input logic [DATA_W-1:0] din,
                                                 input logic [DATA_W-1:0] st,
                                                 input logic [DATA_W-1:0] ct);
    case (a)
      OFS_DATA: return ct[C_DIR] ? din : dw;
      OFS_STAT: return st;
      OFS_CTRL: return ct;
      default:  return UNMAPPED;
    endcase
  endfunction
endpackage

// File: rtl/prn_strobe_edge.sv
module prn_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic rd,
  output logic wr_evt,
  output logic rd_evt
);
  logic [1:0] seen_q;
  logic [1:0] now;
  logic [1:0] rise;

  assign now = {rd, wr};

  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= 2'b00;
    else        seen_q <= now;
  end

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_rise
      assign rise[g] = now[g] & ~seen_q[g];
    end
  endgenerate

  // write wins a simultaneous rise
  assign wr_evt = rise[0];
  assign rd_evt = rise[1] & ~rise[0];
endmodule

// File: rtl/prn_handshake.sv
module prn_handshake
  import prn_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic              rd_evt,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] ctrl,
  output logic              pend,
  output logic              emit
);
  logic [DATA_W-1:0] folded;
  ctl_effect_t       eff;
  logic              ctl_wr;
  logic              stat_rd;

  assign folded  = ctl_fold(wdata);
  assign eff     = ctl_decode(folded, ctrl);
  assign ctl_wr  = wr_evt && (addr == OFS_CTRL);
  assign stat_rd = rd_evt && (addr == OFS_STAT);
  assign emit    = ctl_wr && eff.emit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= STAT_RST;
      ctrl   <= CTRL_RST;
      pend   <= 1'b0;
    end else if (ctl_wr) begin
      if (eff.reload)        status <= STAT_INIT;
      else if (eff.clr_busy) status[S_BUSY] <= 1'b0;
      if (eff.set_pend)      pend <= 1'b1;
      ctrl <= folded;
    end else if (stat_rd) begin
      pend   <= 1'b0;
      status <= poll_step(status, ctrl[C_STRB]);
    end
  end
endmodule

// File: rtl/prn_data_path.sv
module prn_data_path
  import prn_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic              rd_evt,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] status,
  input  logic [DATA_W-1:0] ctrl,
  input  logic              emit,
  output logic [DATA_W-1:0] rdata,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_byte
);
  logic [DATA_W-1:0] dw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dw_q      <= DATA_RST;
      rdata     <= UNMAPPED;
      out_valid <= 1'b0;
      out_byte  <= '0;
    end else begin
      out_valid <= emit;
      if (emit) out_byte <= dw_q;
      if (wr_evt && addr == OFS_DATA) dw_q <= wdata;
      if (rd_evt) rdata <= read_mux(addr, dw_q, din, status, ctrl);
    end
  end
endmodule

// File: rtl/prn_port_regs.sv
module prn_port_regs
  import prn_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] in_byte,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_byte,
  output logic              irq
);
  logic              wr_evt;
  logic              rd_evt;
  logic [DATA_W-1:0] status;
  logic [DATA_W-1:0] ctrl;
  logic              pend;
  logic              emit;

  prn_strobe_edge u_edge (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd),
    .wr_evt(wr_evt), .rd_evt(rd_evt)
  );

  prn_handshake u_hs (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .rd_evt(rd_evt),
    .addr(bus_addr), .wdata(bus_wdata), .status(status), .ctrl(ctrl),
    .pend(pend), .emit(emit)
  );

  prn_data_path u_dp (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .rd_evt(rd_evt),
    .addr(bus_addr), .wdata(bus_wdata), .din(in_byte), .status(status),
    .ctrl(ctrl), .emit(emit), .rdata(bus_rdata), .out_valid(out_valid),
    .out_byte(out_byte)
  );

  assign irq = pend;
endmodule

// File: rtl/prn_port_chk.sv
module prn_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_evt,
  input logic       rd_evt,
  input logic [2:0] bus_addr,
  input logic [7:0] bus_rdata,
  input logic       out_valid,
  input logic       irq
);
  // R10
  wr_once_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_evt |=> !wr_evt);
  // R10
  rd_once_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_evt |=> !rd_evt);
  // R10
  excl_evt_chk: assert property (@(posedge clk) disable iff (!rst_n) !(wr_evt && rd_evt));
  // R5
  out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) out_valid |=> !out_valid);
  // R5
  out_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(wr_evt && bus_addr == 3'd2));
  // R7
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && bus_addr == 3'd1) |=> !irq);
  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(wr_evt && bus_addr == 3'd2));
  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_evt |=> $stable(bus_rdata));
endmodule

bind prn_port_regs prn_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .rd_evt(rd_evt),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .out_valid(out_valid), .irq(irq)
);

// File: tb/prn_port_regs_test.sv
module prn_port_regs_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] in_byte = 8'h00;
  logic       out_valid;
  logic [7:0] out_byte;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit cmp_on = 0;

  // reference model state
  logic [7:0] m_dw, m_st, m_ct, m_rd, m_ob;
  bit m_pend, m_ov, m_pw, m_pr;

  always #2 clk = ~clk;

  prn_port_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .in_byte(in_byte), .out_valid(out_valid), .out_byte(out_byte), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_dw = 8'hFF; m_st = 8'hD9; m_ct = 8'hCC; m_rd = 8'hFF; m_ob = 8'h00;
    m_pend = 0; m_ov = 0; m_pw = 0; m_pr = 0;
  endtask

  task automatic model_step(input bit w, input bit r, input logic [7:0] a,
                            input logic [7:0] d);
    bit we, re;
    logic [7:0] v;
    we = w && !m_pw;
    re = r && !m_pr && !we;
    m_pw = w; m_pr = r;
    m_ov = 0;
    if (we) begin
      if (a == 0) m_dw = d;
      else if (a == 2) begin
        v = d | 8'hC0;
        if (v[2] == 0) m_st = 8'hD8;
        else if (v[3]) begin
          if (v[0]) begin
            m_st = m_st & 8'h7F;
            if (m_ct[0] == 0) begin m_ov = 1; m_ob = m_dw; end
          end else if (m_ct[4]) m_pend = 1;
        end
        m_ct = v;
      end
    end else if (re) begin
      if (a == 0) m_rd = m_ct[5] ? in_byte : m_dw;
      else if (a == 1) begin
        m_rd = m_st;
        m_pend = 0;
        if (m_st[7] == 0 && m_ct[0] == 0) begin
          if (m_st[6]) m_st = m_st & 8'hBF;
          else m_st = m_st | 8'hC0;
        end
      end else if (a == 2) m_rd = m_ct;
      else m_rd = 8'hFF;
    end
  endtask

  // drive at a negedge, advance one clock, compare at the following negedge
  task automatic step(input bit w, input bit r, input logic [2:0] a,
                      input logic [7:0] d);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    model_step(w, r, {5'd0, a}, d);
    @(negedge clk);
    if (cmp_on) begin
      check("R12 model rdata", bus_rdata, m_rd);
      check("R9 model irq", irq, m_pend);
      check("R5 model out_valid", out_valid, m_ov);
      if (m_ov) check("R5 model out_byte", out_byte, m_ob);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    step(1, 0, a, d);
    step(0, 0, a, d);
  endtask

  task automatic rd_reg(input logic [2:0] a, input string req, input logic [7:0] exp);
    step(0, 1, a, 8'h00);
    check(req, bus_rdata, exp);
    step(0, 0, a, 8'h00);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1;
    @(negedge clk);
    // R1 reset values
    check("R1 rdata", bus_rdata, 8'hFF);
    check("R1 irq", irq, 0);
    check("R1 out_valid", out_valid, 0);
    rd_reg(1, "R1 status", 8'hD9);
    rd_reg(2, "R1 control", 8'hCC);
    rd_reg(0, "R1 data", 8'hFF);

    // R2 unmapped offsets and ignored writes
    rd_reg(5, "R2 offset5", 8'hFF);
    rd_reg(3, "R2 offset3", 8'hFF);
    wr_reg(1, 8'h00);
    rd_reg(1, "R2 status write ignored", 8'hD9);
    wr_reg(6, 8'h00);
    rd_reg(2, "R2 offset6 write ignored", 8'hCC);
    rd_reg(0, "R2 data untouched", 8'hFF);

    // R3 and R4
    wr_reg(2, 8'h08);
    rd_reg(2, "R3 forced bits", 8'hC8);
    rd_reg(1, "R4 init reload", 8'hD8);

    // R8 output direction
    wr_reg(0, 8'h5A);
    rd_reg(0, "R8 data out dir", 8'h5A);

    // R6 no pending without stored enable
    wr_reg(2, 8'h1C);
    check("R6 no irq without prior enable", irq, 0);

    // R5 strobe rise emits once
    step(1, 0, 2, 8'h1D);
    check("R5 out_valid", out_valid, 1);
    check("R5 out_byte", out_byte, 8'h5A);
    step(0, 0, 2, 8'h1D);
    check("R5 single pulse", out_valid, 0);
    wr_reg(2, 8'h1D);
    check("R5 no repeat emit", out_valid, 0);

    // R6 / R9 pending with stored enable
    step(1, 0, 2, 8'h1C);
    check("R9 irq next cycle", irq, 1);
    step(0, 0, 2, 8'h1C);
    check("R9 irq held", irq, 1);

    // R7 polled handshake
    rd_reg(1, "R7 status before step", 8'h58);
    check("R7 irq cleared", irq, 0);
    rd_reg(1, "R7 ack cleared", 8'h18);
    rd_reg(1, "R7 ack busy set", 8'hD8);
    rd_reg(1, "R7 busy stops stepping", 8'hD8);

    // R10 held read strobe steps once
    wr_reg(2, 8'h1D);
    wr_reg(2, 8'h1C);
    check("R6 irq re-armed", irq, 1);
    step(0, 1, 1, 8'h00);
    for (int i = 0; i < 4; i++) step(0, 1, 1, 8'h00);
    step(0, 0, 1, 8'h00);
    rd_reg(1, "R10 held read stepped once", 8'h18);

    // R10 simultaneous rise: write wins
    step(1, 1, 0, 8'h33);
    check("R10 collision read dropped", bus_rdata, 8'h18);
    step(0, 0, 0, 8'h00);
    rd_reg(0, "R10 collision write kept", 8'h33);

    // R8 input direction and R11 control read
    in_byte = 8'hA7;
    wr_reg(2, 8'h24);
    rd_reg(0, "R8 data in dir", 8'hA7);
    rd_reg(2, "R11 control read", 8'hE4);
    rd_reg(2, "R11 control read again", 8'hE4);
    rd_reg(0, "R11 data unaffected", 8'hA7);

    // R12 hold through idle and writes
    for (int i = 0; i < 3; i++) step(0, 0, 0, 8'h00);
    check("R12 idle hold", bus_rdata, 8'hA7);
    wr_reg(0, 8'h11);
    check("R12 write hold", bus_rdata, 8'hA7);

    summary();
  end
endmodule